// File: doc/BRIEF.md
# Pointer Override Unit

In a machine whose only operation is a move between two buses of addresses, there is no instruction that follows a pointer. This unit provides that step. It sits between the sequencer's left address output and the address decoders, and it is mapped into the address space as a small window of registers. When a data value is written to its pointer register, the unit takes the low address bits of that value into a short shift pipeline. A fixed number of cycles later, those bits replace whatever left address the program supplied. A move whose left side is a "don't care" then reads or writes the location the pointer named.

The pipeline holds one entry per cycle of delay, and a valid bit travels with each entry. A new pointer can therefore be written in every cycle, including the cycle in which an earlier override is being applied. This lets a chain such as pointer-to-pointer be followed at full rate. When the machine runs in user mode, a data base register is added to the overriding address as it is driven. The last value written, the valid bits and the address held in each slot can all be read and written through the same window, so that a context switch can save and restore the pending overrides.

Top module: `ptr_override_unit`

## Requirements
- R1: After reset no slot is valid, `ovr_active` is 0, `left_addr` equals `seq_left`, and both the pointer register (offset 0) and the state register (offset 1) read 0.
- R2: A write of value V to offset 0 in cycle n makes `left_addr` equal to V[AW-1:0] and `ovr_active` 1 in cycle n+DEPTH (n+2 by default), whatever `seq_left` is. That write causes no override in cycles n+1 through n+DEPTH-1.
- R3: While an override is applied, `left_addr` equals the slot address plus `data_base` (modulo 2^AW) when `user_mode` is 1, and the slot address unmodified when `user_mode` is 0; both inputs are sampled in the cycle the override is driven.
- R4: In a cycle with no valid entry at the pipeline head, `left_addr` equals `seq_left` and `ovr_active` is 0, with no base added in either mode.
- R5: Pointer writes in consecutive cycles each produce their own override, in the order written, in consecutive cycles.
- R6: A read of offset 0 returns the full DW-bit value of the most recent write to offset 0.
- R7: A read of offset 1 returns the valid bits zero-extended: bit i is the valid bit of slot i, slot 0 is the newest entry, and slot DEPTH-1 is the head that drives the bus in the current cycle.
- R8: A write to offset 1 replaces the valid bits with the low DEPTH bits of the data, and the pipeline does not shift in that cycle. Writing 0 flushes every pending override.
- R9: A read of offset 2+k returns the address held in slot k, zero-extended. A write to offset 2+k replaces that address, leaves every valid bit unchanged, and stops the shift for that cycle. A slot that shifts in without a push holds address 0.
- R10: Reads of any address outside BASE_ADDR..BASE_ADDR+DEPTH+1 return 0, and writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_mode | input | 1 | 1 selects user mode, in which the data base is added |
| data_base | input | AW | Data base address added in user mode |
| seq_left | input | AW | Left address from the sequencer |
| wr_en | input | 1 | Data bus write strobe for this cycle |
| wr_addr | input | AW | Destination address of the write |
| wr_data | input | DW | Data bus value |
| rd_addr | input | AW | Source address for the register read |
| rd_data | output | DW | Register read value, 0 outside the window |
| left_addr | output | AW | Left address passed to the decoders |
| ovr_active | output | 1 | An override replaces the left address in this cycle |

## Verification
A shift that misses an entry, or a valid bit that is lost, appears at `left_addr` exactly DEPTH cycles after the pointer write: either the program's own left address comes through, or an override arrives a cycle early or late. A corrupted slot address or a wrong base addition shows up as a wrong address in that same cycle. A state or slot write that fails to stop the shift is visible one cycle later through the state read, and one to DEPTH cycles later as a misplaced override. The bench compares every cycle's bus output, flag and read value against a model, so any of these faults is reported within DEPTH+1 cycles of its cause.

// File: rtl/povr_pkg.sv
package povr_pkg;
    // Register window layout, relative to the unit's base address
    localparam int OFS_PTR   = 0;  // push a pointer; reads the last pushed value
    localparam int OFS_STATE = 1;  // valid bits of the pipeline slots
    localparam int OFS_SLOT0 = 2;  // first of DEPTH slot address registers
    localparam int NCTRL     = 2;  // registers ahead of the slot block
endpackage

// File: rtl/povr_dec.sv
module povr_dec #(
    parameter int             AW        = 16,
    parameter int             NREG      = 4,
    parameter logic [AW-1:0]  BASE_ADDR = '0,
    localparam int            OFW       = $clog2(NREG)
) (
    input  logic [AW-1:0]  addr,
    output logic           hit,
    output logic [OFW-1:0] off
);
    logic [AW-1:0] diff;

    always_comb begin
        diff = addr - BASE_ADDR;
        hit  = (addr >= BASE_ADDR) && (diff < AW'(NREG));
        off  = diff[OFW-1:0];
    end
endmodule

// File: rtl/povr_pipe.sv
module povr_pipe #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 2   // at least 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [DW-1:0]             push_data,
    input  logic                      st_wr,
    input  logic [DEPTH-1:0]          st_val,
    input  logic [DEPTH-1:0]          sl_wr,
    input  logic [AW-1:0]             sl_val,
    output logic [DEPTH-1:0]          valid,
    output logic [DEPTH-1:0][AW-1:0]  slot_a,
    output logic [DW-1:0]             last
);
    typedef struct packed {
        logic [DEPTH-1:0]          v;
        logic [DEPTH-1:0][AW-1:0]  a;
        logic [DW-1:0]             last;
    } pipe_t;

    pipe_t q, d;
    logic  hold;

    always_comb begin
        d    = q;
        hold = st_wr || (|sl_wr);
        if (!hold) begin
            for (int i = 1; i < DEPTH; i++) begin
                d.v[i] = q.v[i-1];
                d.a[i] = q.a[i-1];
            end
            d.v[0] = push;
            d.a[0] = push ? push_data[AW-1:0] : '0;
        end
        if (st_wr) begin
            d.v = st_val;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (sl_wr[i]) begin
                d.a[i] = sl_val;
            end
        end
        if (push) begin
            d.last = push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign valid  = q.v;
    assign slot_a = q.a;
    assign last   = q.last;

    AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> q.v[0]); // R2
    AST_STATE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr |=> q.v == $past(st_val)); // R8
    AST_SLOT_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (|sl_wr) |=> $stable(q.v)); // R9
    AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_wr || (|sl_wr)) |=> q.v[DEPTH-1:1] == $past(q.v[DEPTH-2:0])); // R5
endmodule

// File: rtl/povr_drive.sv
module povr_drive #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_v,
    input  logic [AW-1:0] head_a,
    input  logic          user_mode,
    input  logic [AW-1:0] data_base,
    input  logic [AW-1:0] seq_left,
    output logic [AW-1:0] left_out,
    output logic          ovr_active
);
    logic [AW-1:0] rebased;

    always_comb begin
        rebased    = user_mode ? (head_a + data_base) : head_a;
        left_out   = head_v ? rebased : seq_left;
        ovr_active = head_v;
    end

    AST_SYS_NO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (head_v && !user_mode) |-> left_out == head_a); // R3
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !head_v |-> (left_out == seq_left) && !ovr_active); // R4
endmodule

// File: rtl/ptr_override_unit.sv
module ptr_override_unit #(
    parameter int             AW        = 16,
    parameter int             DW        = 32,
    parameter int             DEPTH     = 2,
    parameter logic [AW-1:0]  BASE_ADDR = 16'hFF00
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           user_mode,
    input  logic [AW-1:0]  data_base,
    input  logic [AW-1:0]  seq_left,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    output logic [AW-1:0]  left_addr,
    output logic           ovr_active
);
    import povr_pkg::*;

    localparam int NREG = NCTRL + DEPTH;
    localparam int OFW  = $clog2(NREG);

    logic                      wr_hit, rd_hit;
    logic [OFW-1:0]            wr_off, rd_off;
    logic                      push, st_wr;
    logic [DEPTH-1:0]          sl_wr;
    logic [DEPTH-1:0]          valid;
    logic [DEPTH-1:0][AW-1:0]  slot_a;
    logic [DW-1:0]             last;

    povr_dec #(.AW(AW), .NREG(NREG), .BASE_ADDR(BASE_ADDR)) u_wr_dec (
        .addr(wr_addr), .hit(wr_hit), .off(wr_off)
    );
    povr_dec #(.AW(AW), .NREG(NREG), .BASE_ADDR(BASE_ADDR)) u_rd_dec (
        .addr(rd_addr), .hit(rd_hit), .off(rd_off)
    );

    assign push  = wr_en && wr_hit && (int'(wr_off) == OFS_PTR);
    assign st_wr = wr_en && wr_hit && (int'(wr_off) == OFS_STATE);

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot_wr
        assign sl_wr[k] = wr_en && wr_hit && (int'(wr_off) == OFS_SLOT0 + k);
    end

    povr_pipe #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(wr_data),
        .st_wr(st_wr), .st_val(wr_data[DEPTH-1:0]),
        .sl_wr(sl_wr), .sl_val(wr_data[AW-1:0]),
        .valid(valid), .slot_a(slot_a), .last(last)
    );

    povr_drive #(.AW(AW)) u_drive (
        .clk(clk), .rst_n(rst_n),
        .head_v(valid[DEPTH-1]), .head_a(slot_a[DEPTH-1]),
        .user_mode(user_mode), .data_base(data_base),
        .seq_left(seq_left), .left_out(left_addr), .ovr_active(ovr_active)
    );

    always_comb begin
        rd_data = '0;
        if (rd_hit) begin
            if (int'(rd_off) == OFS_PTR) begin
                rd_data = last;
            end else if (int'(rd_off) == OFS_STATE) begin
                rd_data = DW'(valid);
            end else begin
                for (int k = 0; k < DEPTH; k++) begin
                    if (int'(rd_off) == OFS_SLOT0 + k) begin
                        rd_data = DW'(slot_a[k]);
                    end
                end
            end
        end
    end

    AST_READ_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> rd_data == '0); // R10
    AST_OVERRIDE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_active |-> $past(push || st_wr || (|valid))); // R2
endmodule

// File: tb/ptr_override_unit_test.sv
`timescale 1ns/1ps
module ptr_override_unit_test;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int D  = 2;
    localparam logic [AW-1:0] BASE = 16'hFF00;
    localparam int NREG = D + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic user_mode = 1'b0;
    logic [AW-1:0] data_base = '0;
    logic [AW-1:0] seq_left = '0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] left_addr;
    logic ovr_active;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic [D-1:0]          mv = '0;
    logic [D-1:0][AW-1:0]  ma = '0;
    logic [DW-1:0]         mlast = '0;

    always #10 clk = ~clk;  // 50 MHz

    ptr_override_unit #(.AW(AW), .DW(DW), .DEPTH(D), .BASE_ADDR(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .user_mode(user_mode), .data_base(data_base),
        .seq_left(seq_left), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .left_addr(left_addr),
        .ovr_active(ovr_active)
    );

    function automatic bit in_win(input logic [AW-1:0] a);
        return (a >= BASE) && (int'(a - BASE) < NREG);
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
        int o;
        if (!in_win(a)) return '0;  // R10
        o = int'(a - BASE);
        if (o == 0) return mlast;         // R6
        if (o == 1) return DW'(mv);       // R7
        return DW'(ma[o-2]);              // R9
    endfunction

    function automatic logic [AW-1:0] exp_left();
        if (!mv[D-1]) return seq_left;    // R4
        return user_mode ? ma[D-1] + data_base : ma[D-1];  // R2, R3
    endfunction

    function automatic string rd_tag(input logic [AW-1:0] a);
        int o;
        if (!in_win(a)) return "R10";
        o = int'(a - BASE);
        if (o == 0) return "R6";
        if (o == 1) return "R7";
        return "R9";
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One instruction cycle: drive at negedge, check mid-phase, advance model
    task automatic step(input string tag, input logic we, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd, input logic [AW-1:0] ra);
        bit hit;
        int o;
        bit hold;
        string lt;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        #5;
        lt = !mv[D-1] ? "R4" : (user_mode ? "R3" : "R2");
        check($sformatf("%s/%s left", tag, lt), DW'(left_addr), DW'(exp_left()));
        check($sformatf("%s/%s active", tag, lt), DW'(ovr_active), DW'(mv[D-1]));
        check($sformatf("%s/%s read", tag, rd_tag(ra)), rd_data, exp_rd(ra));
        hit  = we && in_win(wa);
        o    = hit ? int'(wa - BASE) : -1;
        hold = hit && (o >= 1);
        if (!hold) begin
            for (int i = D-1; i >= 1; i--) begin
                mv[i] = mv[i-1];
                ma[i] = ma[i-1];
            end
            mv[0] = (o == 0);
            ma[0] = (o == 0) ? wd[AW-1:0] : '0;
        end
        if (o == 1) mv = wd[D-1:0];
        if (o >= 2) ma[o-2] = wd[AW-1:0];
        if (o == 0) mlast = wd;
    endtask

    task automatic idle(input string tag, input logic [AW-1:0] ra);
        step(tag, 1'b0, '0, '0, ra);
    endtask

    initial begin : watchdog
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        seq_left = 16'h1111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        idle("R1", BASE);
        idle("R1", BASE + 16'd1);

        // R2: single pointer, override two cycles later, system mode
        seq_left = 16'h2222;
        step("R2", 1'b1, BASE, 32'h1234ABCD, BASE + 16'd1);
        idle("R2", BASE + 16'd1);   // no override yet, R7 state reads 01
        idle("R2", BASE + 16'd1);   // override 0xABCD, state reads 10
        idle("R4", BASE);           // R6 last = 0x1234ABCD

        // R3: user mode adds data base with wrap
        user_mode = 1'b1; data_base = 16'h0100;
        step("R3", 1'b1, BASE, 32'h0000FFF0, BASE + 16'd3);
        idle("R3", BASE + 16'd3);
        idle("R3", BASE + 16'd1);   // expect 0x00F0
        idle("R4", BASE + 16'd1);   // R4: no base when nothing pending

        // R5: back-to-back pushes, chained
        user_mode = 1'b0;
        step("R5", 1'b1, BASE, 32'h00000A01, BASE);
        step("R5", 1'b1, BASE, 32'h00000A02, BASE);
        step("R5", 1'b1, BASE, 32'h00000A03, BASE);
        idle("R5", BASE + 16'd1);
        idle("R5", BASE);
        idle("R6", BASE);

        // R8: flush with state write of zero
        step("R8", 1'b1, BASE, 32'h00005555, BASE + 16'd1);
        step("R8", 1'b1, BASE + 16'd1, 32'h0, BASE + 16'd1);
        idle("R8", BASE + 16'd1);
        idle("R8", BASE + 16'd1);
        // R8/R9: restore a context: slot data then valid bits
        step("R9", 1'b1, BASE + 16'd3, 32'h0000BEEF, BASE + 16'd3);
        step("R9", 1'b1, BASE + 16'd2, 32'h0000CAFE, BASE + 16'd2);
        step("R8", 1'b1, BASE + 16'd1, 32'h00000003, BASE + 16'd1);
        idle("R8", BASE + 16'd1);   // BEEF drives
        idle("R8", BASE + 16'd1);   // CAFE drives

        // R10: out-of-window accesses
        step("R10", 1'b1, BASE + 16'd4, 32'hFFFFFFFF, BASE + 16'd4);
        step("R10", 1'b1, BASE - 16'd1, 32'h00000003, BASE - 16'd1);
        idle("R10", BASE + 16'd1);
        idle("R10", BASE + 16'd1);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] wa, ra;
            logic [DW-1:0] wd;
            user_mode = 1'($urandom);
            data_base = 16'($urandom);
            seq_left  = 16'($urandom);
            wa = BASE + 16'($urandom_range(0, 6)) - 16'd1;
            ra = BASE + 16'($urandom_range(0, 6)) - 16'd1;
            wd = $urandom;
            if (int'(wa - BASE) == 1 && ($urandom_range(0, 3) == 0)) wd = '0;
            step("RND", ($urandom_range(0, 9) < 6), wa, wd, ra);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule